// File: doc/BRIEF.md
# Reed-Solomon Syndrome Calculator

This block is the first stage of a Reed-Solomon decoder for 8-bit symbols with six parity symbols per codeword (the (255,249) code). A received codeword streams in one symbol per accepted beat, highest-degree symbol first. Six accumulators run side by side. Each one evaluates the received polynomial r(x) at one root of the generator polynomial, using Horner's rule. The roots are alpha^0 through alpha^5 in GF(2^8), where alpha is a root of x^8+x^4+x^3+x^2+1 (0x11D).

Each syndrome depends only on the error pattern added to a valid codeword. A clean codeword therefore gives six zero syndromes. When the last symbol has been taken in, the block presents all six syndromes together with a flag that says whether every one of them is zero. A later stage (locator solving, root search, magnitude computation) uses them. That stage is outside this block.

A shortened codeword is simply a shorter stream. Leading zero symbols contribute nothing to a Horner evaluation, so no padding is needed.

Top module: `rsyn_calc`

## Requirements
- R1: While reset is high and on the first cycle after it, `syn_valid` is 0, `syn_zero` is 0 and `syn_out` is all zero.
- R2: Lane i of `syn_out` (bits 8i+7..8i) equals the sum over the block of r_t·alpha^(i·d_t). Here d_t is the degree of symbol t: the first symbol of an n-symbol block has degree n-1 and the last has degree 0. Multiplication is in GF(2^8) modulo 0x11D and alpha = 0x02.
- R3: `syn_valid` is high for exactly the one cycle after a beat that has `in_valid` and `in_last` both high, and it is low in every other cycle.
- R4: A codeword produced by the systematic encoder with generator (x+alpha^0)…(x+alpha^5) gives six zero syndromes and `syn_zero` = 1.
- R5: When `syn_valid` is high, `syn_zero` is 1 exactly when all six lanes are zero. With one to three symbol errors in a codeword it is 0.
- R6: A beat with `in_first` high starts a new block and discards whatever was accumulated before, including an unfinished block. A new block may start on the cycle right after a last beat. A beat with both `in_first` and `in_last` gives S_i = that symbol for every i.
- R7: Cycles with `in_valid` low do not change the accumulation, whatever `in_sym`, `in_first` and `in_last` hold.
- R8: A shortened block of n < 255 symbols gives the same syndromes as the full 255-symbol block padded in front with zeros. A shortened valid codeword gives `syn_zero` = 1.
- R9: `syn_out` and `syn_zero` keep their values between strobes until the next last beat.
- R10: A single wrong symbol counts as one error whether one bit or all eight bits differ. For an error value e at degree p, S_0 = e.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Beat qualifier for the symbol inputs |
| in_first | input | 1 | Beat carries the first (highest-degree) symbol of a block |
| in_last | input | 1 | Beat carries the last (degree-0) symbol of a block |
| in_sym | input | 8 | Received symbol |
| syn_valid | output | 1 | One-cycle strobe: syndromes are ready |
| syn_out | output | 48 | Six syndromes, lane i in bits 8i+7..8i holds S_i |
| syn_zero | output | 1 | All six syndromes are zero |

## Verification
The stimulus starts with full-length codewords from a bench-side systematic encoder. Clean ones must give zero syndromes, and the same words with one, two or three random symbol errors are compared lane by lane with an ascending-power evaluator. This separates a wrong root exponent, a wrong reduction polynomial or a reversed symbol order from a correct design. Shortened codewords, single-bit and all-bit errors, and one-symbol blocks probe the degree bookkeeping and the first-beat load. Random idle gaps with garbage on the inputs, back-to-back blocks and an abandoned partial block show that the accumulation honours the beat qualifier and restarts only on a first beat.

// File: rtl/rsyn_pkg.sv
package rsyn_pkg;

    parameter int          SYM_W     = 8;
    parameter int          NUM_SYN   = 6;
    parameter logic [8:0]  PRIM_POLY = 9'h11D;

    typedef logic [SYM_W-1:0] sym_t;

    typedef struct packed {
        logic valid;
        logic first;
        logic last;
        sym_t data;
    } sym_beat_t;

    // Multiply two field elements, reducing modulo PRIM_POLY.
    function automatic sym_t gf_mul(sym_t a, sym_t b);
        sym_t prod;
        sym_t shifted;
        prod    = '0;
        shifted = a;
        for (int k = 0; k < SYM_W; k++) begin
            if (b[k]) prod = prod ^ shifted;
            if (shifted[SYM_W-1])
                shifted = (shifted << 1) ^ PRIM_POLY[SYM_W-1:0];
            else
                shifted = shifted << 1;
        end
        return prod;
    endfunction

    // alpha^e, with alpha = x (0x02).
    function automatic sym_t alpha_pow(int e);
        sym_t r;
        r = sym_t'(1);
        for (int k = 0; k < e; k++) r = gf_mul(r, sym_t'(2));
        return r;
    endfunction

endpackage

// File: rtl/rsyn_horner_cell.sv
module rsyn_horner_cell
    import rsyn_pkg::*;
#(
    parameter int ROOT_EXP = 0
) (
    input  logic      clk,
    input  logic      rst,
    input  sym_beat_t beat,
    output sym_t      acc_next
);
    localparam sym_t ROOT = alpha_pow(ROOT_EXP);

    sym_t acc_q;

    // One Horner step: previous partial value times the root, plus the new symbol.
    always_comb begin
        if (beat.first)
            acc_next = beat.data;
        else
            acc_next = gf_mul(acc_q, ROOT) ^ beat.data;
    end

    always_ff @(posedge clk) begin
        if (rst)
            acc_q <= '0;
        else if (beat.valid)
            acc_q <= acc_next;
    end
endmodule

// File: rtl/rsyn_zero_detect.sv
module rsyn_zero_detect
    import rsyn_pkg::*;
#(
    parameter int LANES = NUM_SYN
) (
    input  sym_t [LANES-1:0] lanes,
    output logic             all_zero
);
    logic [LANES-1:0] lane_nz;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_nz[g] = |lanes[g];
    end

    assign all_zero = ~|lane_nz;
endmodule

// File: rtl/rsyn_calc.sv
module rsyn_calc
    import rsyn_pkg::*;
#(
    parameter int FIRST_ROOT = 0
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    input  logic                       in_first,
    input  logic                       in_last,
    input  logic [SYM_W-1:0]           in_sym,
    output logic                       syn_valid,
    output logic [NUM_SYN*SYM_W-1:0]   syn_out,
    output logic                       syn_zero
);
    localparam int OUT_W = NUM_SYN * SYM_W;

    sym_beat_t          beat;
    sym_t [NUM_SYN-1:0] lane_next;
    logic               next_zero;
    logic               close_block;

    assign beat        = '{valid: in_valid, first: in_first, last: in_last, data: in_sym};
    assign close_block = beat.valid && beat.last;

    for (genvar g = 0; g < NUM_SYN; g++) begin : g_root
        rsyn_horner_cell #(
            .ROOT_EXP (FIRST_ROOT + g)
        ) i_cell (
            .clk      (clk),
            .rst      (rst),
            .beat     (beat),
            .acc_next (lane_next[g])
        );
    end

    rsyn_zero_detect #(
        .LANES (NUM_SYN)
    ) i_zero (
        .lanes    (lane_next),
        .all_zero (next_zero)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            syn_valid <= 1'b0;
            syn_out   <= '0;
            syn_zero  <= 1'b0;
        end else begin
            syn_valid <= close_block;
            if (close_block) begin
                syn_out  <= OUT_W'(lane_next);
                syn_zero <= next_zero;
            end
        end
    end
endmodule

// File: rtl/rsyn_calc_chk.sv
module rsyn_calc_chk
    import rsyn_pkg::*;
(
    input logic                     clk,
    input logic                     rst,
    input logic                     in_valid,
    input logic                     in_last,
    input logic                     syn_valid,
    input logic [NUM_SYN*SYM_W-1:0] syn_out,
    input logic                     syn_zero
);
    p_strobe_after_last_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_last) |=> syn_valid);

    p_no_stray_strobe_r3: assert property (@(posedge clk) disable iff (rst)
        !(in_valid && in_last) |=> !syn_valid);

    p_flag_agrees_r5: assert property (@(posedge clk) disable iff (rst)
        syn_valid |-> (syn_zero == (syn_out == '0)));

    p_hold_between_r9: assert property (@(posedge clk) disable iff (rst)
        !(in_valid && in_last) |=> ($stable(syn_out) && $stable(syn_zero)));

    p_strobe_single_r3: assert property (@(posedge clk) disable iff (rst)
        (syn_valid && !(in_valid && in_last)) |=> !syn_valid);
endmodule

bind rsyn_calc rsyn_calc_chk i_rsyn_calc_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_last   (in_last),
    .syn_valid (syn_valid),
    .syn_out   (syn_out),
    .syn_zero  (syn_zero)
);

// File: tb/test_rsyn_calc.sv
module test_rsyn_calc;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid, in_first, in_last;
    logic [7:0]  in_sym;
    logic        syn_valid;
    logic [47:0] syn_out;
    logic        syn_zero;

    int checks   = 0;
    int failures = 0;

    always #4 clk = ~clk;   // 125 MHz

    rsyn_calc i_rsyn_calc (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_first(in_first),
        .in_last(in_last), .in_sym(in_sym), .syn_valid(syn_valid),
        .syn_out(syn_out), .syn_zero(syn_zero)
    );

    // ---------------- bench-side field arithmetic ----------------
    function automatic logic [7:0] fmul(logic [7:0] a, logic [7:0] b);
        logic [15:0] p;
        p = '0;
        for (int k = 0; k < 8; k++) if (b[k]) p = p ^ (16'(a) << k);
        for (int k = 15; k >= 8; k--) if (p[k]) p = p ^ (16'h011D << (k - 8));
        return p[7:0];
    endfunction

    logic [7:0] gen [7];
    logic [7:0] cw  [256];
    logic [7:0] rts [6];

    task automatic build_gen();
        logic [7:0] root;
        for (int j = 0; j < 7; j++) gen[j] = 8'h00;
        gen[0] = 8'h01;
        root   = 8'h01;
        for (int i = 0; i < 6; i++) begin
            for (int j = 6; j >= 1; j--) gen[j] = gen[j-1] ^ fmul(gen[j], root);
            gen[0] = fmul(gen[0], root);
            rts[i] = root;
            root   = fmul(root, 8'h02);
        end
    endtask

    // Fill cw[0..n-1] with n-6 random data symbols followed by 6 parity symbols.
    task automatic encode(int n);
        logic [7:0] par [6];
        logic [7:0] fb;
        for (int j = 0; j < 6; j++) par[j] = 8'h00;
        for (int t = 0; t < n - 6; t++) begin
            cw[t] = 8'($urandom);
            fb    = cw[t] ^ par[5];
            for (int j = 5; j >= 1; j--) par[j] = par[j-1] ^ fmul(fb, gen[j]);
            par[0] = fmul(fb, gen[0]);
        end
        for (int j = 0; j < 6; j++) cw[n-6+j] = par[5-j];
    endtask

    // Ascending-power evaluation (degree 0 is the last symbol).
    function automatic logic [47:0] model(int n);
        logic [47:0] s;
        logic [7:0]  pw;
        logic [7:0]  acc;
        s = '0;
        for (int i = 0; i < 6; i++) begin
            acc = 8'h00;
            pw  = 8'h01;
            for (int t = n - 1; t >= 0; t--) begin
                acc = acc ^ fmul(cw[t], pw);
                pw  = fmul(pw, rts[i]);
            end
            s[i*8 +: 8] = acc;
        end
        return s;
    endfunction

    // ---------------- checking ----------------
    task automatic check(bit ok, string req, logic [47:0] act, logic [47:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    logic [47:0] exp_syn_q [$];
    bit          exp_zero_q [$];
    string       exp_tag_q [$];
    bit          prev_close = 1'b0;
    bit          have_prev  = 1'b0;
    logic [47:0] held_syn;
    bit          held_zero;

    // Sample outputs from the previous edge, then drive the next beat.
    task automatic step(bit v, bit f, bit l, logic [7:0] s);
        logic [47:0] e;
        bit          ez;
        string       tg;
        @(negedge clk);
        check(syn_valid == prev_close, "R3", 48'(syn_valid), 48'(prev_close));
        if (syn_valid && exp_syn_q.size() > 0) begin
            e  = exp_syn_q.pop_front();
            ez = exp_zero_q.pop_front();
            tg = exp_tag_q.pop_front();
            check(syn_out == e, tg, syn_out, e);
            check(syn_zero == ez, "R5", 48'(syn_zero), 48'(ez));
            held_syn  = syn_out;
            held_zero = syn_zero;
            have_prev = 1'b1;
        end else if (!syn_valid && have_prev) begin
            check(syn_out == held_syn && syn_zero == held_zero, "R9", syn_out, held_syn);
        end
        in_valid   = v;
        in_first   = f;
        in_last    = l;
        in_sym     = s;
        prev_close = v && l;
    endtask

    task automatic idle();
        step(1'b0, 1'($urandom), 1'($urandom), 8'($urandom));
    endtask

    // Send cw[0..n-1]; gaps=1 inserts random idle cycles with junk inputs.
    task automatic send(int n, bit gaps, string tag);
        logic [47:0] e;
        e = model(n);
        exp_syn_q.push_back(e);
        exp_zero_q.push_back(e == '0);
        exp_tag_q.push_back(tag);
        for (int t = 0; t < n; t++) begin
            if (gaps) while ($urandom_range(0, 3) == 0) idle();
            step(1'b1, t == 0, t == n - 1, cw[t]);
        end
    endtask

    task automatic corrupt(int n, int count);
        int pos;
        logic [7:0] ev;
        for (int c = 0; c < count; c++) begin
            pos = $urandom_range(0, n - 1);
            ev  = 8'($urandom_range(1, 255));
            cw[pos] = cw[pos] ^ ev;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        build_gen();
        rst = 1'b1; in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0; in_sym = 8'h00;
        repeat (3) @(negedge clk);
        // R1: outputs cleared during reset
        check(syn_valid == 1'b0 && syn_out == '0 && syn_zero == 1'b0, "R1",
              {syn_out[46:0], syn_valid}, 48'h0);
        rst = 1'b0;
        @(negedge clk);
        check(syn_valid == 1'b0 && syn_out == '0 && syn_zero == 1'b0, "R1",
              {syn_out[46:0], syn_valid}, 48'h0);

        // R4: clean full-length codewords give zero syndromes
        for (int b = 0; b < 4; b++) begin
            encode(255);
            send(255, 1'b0, "R4");
            idle();
        end
        // R2 / R5: 1..3 random symbol errors, against the evaluator
        for (int b = 0; b < 9; b++) begin
            encode(255);
            corrupt(255, 1 + (b % 3));
            send(255, 1'b0, "R2");
            idle();
        end
        // R8: shortened codewords, clean and corrupted
        for (int b = 0; b < 4; b++) begin
            encode(7 + b * 40);
            send(7 + b * 40, 1'b0, "R8");
            idle();
            corrupt(7 + b * 40, 2);
            send(7 + b * 40, 1'b0, "R8");
            idle();
        end
        // R10: one error with a single bit, then with all bits, S_0 must equal the error value
        encode(100);
        cw[37] = cw[37] ^ 8'h10;
        send(100, 1'b0, "R10");
        idle();
        encode(100);
        cw[99] = cw[99] ^ 8'hFF;
        send(100, 1'b0, "R10");
        idle();
        check(syn_out[7:0] == 8'hFF, "R10", 48'(syn_out[7:0]), 48'hFF);
        // R7: random stalls with junk on the inputs
        for (int b = 0; b < 3; b++) begin
            encode(255);
            if (b != 0) corrupt(255, b);
            send(255, 1'b1, "R7");
        end
        // R6: back-to-back blocks, no idle between last and first
        for (int b = 0; b < 3; b++) begin
            encode(60);
            if (b == 1) corrupt(60, 3);
            send(60, 1'b0, "R6");
        end
        // R6: an abandoned partial block is discarded
        for (int t = 0; t < 10; t++) step(1'b1, t == 0, 1'b0, 8'($urandom));
        encode(80);
        corrupt(80, 1);
        send(80, 1'b0, "R6");
        // R6: one-symbol blocks, S_i = symbol in every lane
        for (int b = 0; b < 3; b++) begin
            cw[0] = 8'($urandom);
            send(1, 1'b0, "R6");
        end
        cw[0] = 8'h00;
        send(1, 1'b0, "R6");
        repeat (4) idle();
        check(exp_syn_q.size() == 0, "R3", 48'(exp_syn_q.size()), 48'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule